// File: doc/BRIEF.md
# UART Fractional Baud Tick Generator

This block derives the 16x oversampling tick that drives a UART's transmit and receive bit timing from the peripheral clock. It works in two stages. The first is a programmable integer divider whose divisor is made of a high byte and a low byte. The second is a fractional stage that sometimes holds back a tick for one extra divider period. For every `mul` ticks the block spends `mul + add` divider periods, so the average tick rate is clk / (N × (1 + add/mul)). Dividing that rate by the 16x oversampling factor gives the baud rate.

Settings are captured into shadow registers only while `run` is low. A rate change therefore always lands between transfers and never corrupts a character in flight. An illegal fractional setting raises `cfg_err`, and the block then falls back to integer-only division. A divisor of zero is treated as one, so the tick never stalls.

Top module: `baud_frac_gen`

## Requirements
- R1: With a legal fractional setting and effective divisor N, the block emits exactly `mul` ticks for every N × (`mul` + `add`) clock cycles of `run` high. Any window aligned to the start of `run` therefore holds that many ticks to within one.
- R2: The fractional byte carries the add value in bits 3:0 and the multiplier in bits 7:4. The divisor is `div_hi` × 256 + `div_lo`.
- R3: When the add value is 0, the block emits one tick every N cycles exactly, for any multiplier from 1 to 15.
- R4: A fractional setting is illegal when the multiplier is 0 or when the add value is not below the multiplier. Such a setting drives `cfg_err` to 1 and gives one tick every N cycles. A legal setting drives `cfg_err` to 0.
- R5: A combined divisor of 0 behaves exactly like a divisor of 1.
- R6: The divisor and fractional inputs are captured only on clock edges at which `run` is low. Changes to them while `run` is high leave the tick rate unchanged.
- R7: Ticks are generated only while `run` is high. The first tick appears in the cycle after the first clock edge that samples `run` high. After `run` is sampled low, `tick` is 0 from the next cycle on.
- R8: `tick` is a single-cycle pulse. When the effective divisor is 2 or more, it is never high on two consecutive cycles.
- R9: Reset loads add = 0, multiplier = 1 and divisor = 0 (treated as 1). While reset is held, `tick` and `cfg_err` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| div_hi | input | 8 | Upper byte of integer divisor |
| div_lo | input | 8 | Lower byte of integer divisor |
| frac_cfg | input | 8 | Fractional setting: add in [3:0], multiplier in [7:4] |
| run | input | 1 | High while a transfer is active; low permits loading settings |
| tick | output | 1 | One-cycle 16x oversample tick |
| cfg_err | output | 1 | Captured fractional setting is illegal |

## Verification
The assertions assume that the captured settings hold still for as long as `run` stays high. The stability property relies on the shadow registers, not on the raw inputs, so the bench is free to change the inputs mid-run to exercise R6. The rate checks assume that `run` stays high across the whole counting window and that settings are applied with `run` low for at least two edges. The bench drives every configuration step in that order: drop `run`, present the values, wait, check `cfg_err`, then raise `run`. It sweeps every 8-bit fractional value against several small divisors, one divisor that uses the high byte, and divisor zero.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
    parameter int BYTE_W  = 8;
    parameter int FIELD_W = 4;
    localparam int DIV_W  = 2 * BYTE_W;
    localparam int ACC_W  = FIELD_W + 1;

    typedef struct packed {
        logic [FIELD_W-1:0] mul;
        logic [FIELD_W-1:0] add;
    } frac_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        frac_t            frac;
    } cfg_t;

    function automatic logic frac_legal(frac_t f);
        return (f.mul != '0) && (f.add < f.mul);
    endfunction

    function automatic logic [DIV_W-1:0] eff_div(logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction
endpackage

// File: rtl/bfg_cfg_shadow.sv
module bfg_cfg_shadow
    import bfg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  logic [BYTE_W-1:0]      div_hi,
    input  logic [BYTE_W-1:0]      div_lo,
    input  logic [2*FIELD_W-1:0]   frac_raw,
    output logic [DIV_W-1:0]       div_eff,
    output logic [FIELD_W-1:0]     add_eff,
    output logic [FIELD_W-1:0]     mul_eff,
    output logic                   cfg_err
);
    cfg_t cfg_q;
    logic legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.div      <= '0;
            cfg_q.frac.mul <= FIELD_W'(1);
            cfg_q.frac.add <= '0;
        end else if (!run) begin
            cfg_q.div  <= {div_hi, div_lo};
            cfg_q.frac <= frac_t'(frac_raw);
        end
    end

    always_comb begin
        legal   = frac_legal(cfg_q.frac);
        cfg_err = !legal;
        div_eff = eff_div(cfg_q.div);
        add_eff = legal ? cfg_q.frac.add : '0;
        mul_eff = legal ? cfg_q.frac.mul : FIELD_W'(1);
    end

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(cfg_q));
endmodule

// File: rtl/bfg_int_div.sv
module bfg_int_div
    import bfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_eff,
    output logic             tc
);
    logic [DIV_W-1:0] cnt_q;

    assign tc = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q == '0)
            cnt_q <= div_eff - DIV_W'(1);
        else
            cnt_q <= cnt_q - DIV_W'(1);
    end

    // R1 R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < div_eff);
endmodule

// File: rtl/bfg_frac_stretch.sv
module bfg_frac_stretch
    import bfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               tc,
    input  logic [FIELD_W-1:0] add_eff,
    input  logic [FIELD_W-1:0] mul_eff,
    output logic               tick_en
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] mul_x;
    logic             skip_q;

    always_comb begin
        mul_x   = {1'b0, mul_eff};
        sum     = acc_q + {1'b0, add_eff};
        tick_en = tc && !skip_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc_q  <= '0;
            skip_q <= 1'b0;
        end else if (tc) begin
            if (skip_q) begin
                skip_q <= 1'b0;
            end else if (sum >= mul_x) begin
                acc_q  <= sum - mul_x;
                skip_q <= 1'b1;
            end else begin
                acc_q  <= sum;
            end
        end
    end

    // R1
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        acc_q < mul_x);

    // R3 R4
    skip_needs_add_chk: assert property (@(posedge clk) disable iff (rst)
        skip_q |-> (add_eff != '0));
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
    import bfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BYTE_W-1:0]    div_hi,
    input  logic [BYTE_W-1:0]    div_lo,
    input  logic [2*FIELD_W-1:0] frac_cfg,
    input  logic                 run,
    output logic                 tick,
    output logic                 cfg_err
);
    logic [DIV_W-1:0]   div_eff;
    logic [FIELD_W-1:0] add_eff;
    logic [FIELD_W-1:0] mul_eff;
    logic               tc;
    logic               tick_en;
    logic               tick_q;

    bfg_cfg_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div_hi   (div_hi),
        .div_lo   (div_lo),
        .frac_raw (frac_cfg),
        .div_eff  (div_eff),
        .add_eff  (add_eff),
        .mul_eff  (mul_eff),
        .cfg_err  (cfg_err)
    );

    bfg_int_div u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_eff (div_eff),
        .tc      (tc)
    );

    bfg_frac_stretch u_frac (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tc      (tc),
        .add_eff (add_eff),
        .mul_eff (mul_eff),
        .tick_en (tick_en)
    );

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= tick_en;
    end

    assign tick = tick_q;

    // R8
    no_double_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div_eff > DIV_W'(1)) |=> !tick);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);

    // R4
    err_no_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (add_eff == '0));
endmodule

// File: tb/baud_frac_gen_tb.sv
module baud_frac_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_hi = 8'd0;
    logic [7:0] div_lo = 8'd1;
    logic [7:0] frac_cfg = 8'h00;
    logic       run = 1'b0;
    logic       tick;
    logic       cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    baud_frac_gen u_dut (
        .clk(clk), .rst(rst), .div_hi(div_hi), .div_lo(div_lo),
        .frac_cfg(frac_cfg), .run(run), .tick(tick), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply settings with run low, check cfg_err, run for one rate period set.
    task automatic run_cfg(input int n, input int a, input int m, input int k, input string req);
        int  neff, ae, me, per, cnt;
        bit  legal, prev, rep;
        neff  = (n == 0) ? 1 : n;
        legal = (m != 0) && (a < m);
        ae    = legal ? a : 0;
        me    = legal ? m : 1;
        per   = k * neff * (me + ae);
        @(negedge clk);
        run      = 1'b0;
        div_hi   = 8'((n >> 8) & 255);
        div_lo   = 8'(n & 255);
        frac_cfg = {4'(m), 4'(a)};
        @(negedge clk);
        @(negedge clk);
        check(cfg_err == !legal, "R4 cfg_err", int'(cfg_err), int'(!legal));
        run  = 1'b1;
        cnt  = 0;
        prev = 1'b0;
        rep  = 1'b0;
        for (int i = 1; i <= per; i++) begin
            @(negedge clk);
            if (i == 1) check(tick == 1'b1, "R7 first tick", int'(tick), 1);
            if (tick) cnt++;
            if (tick && prev) rep = 1'b1;
            prev = tick;
        end
        check((cnt >= k*me - 1) && (cnt <= k*me + 1), req, cnt, k*me);
        if (neff >= 2) check(!rep, "R8 back-to-back tick", int'(rep), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int divs[5] = '{0, 1, 2, 3, 5};
        // R9: reset values hold even with an illegal byte on the input
        frac_cfg = 8'h00;
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R9 tick in reset", int'(tick), 0);
        check(cfg_err == 1'b0, "R9 cfg_err in reset", int'(cfg_err), 0);
        rst = 1'b0;

        // Sweep every fractional byte (R2 field positions) over small divisors
        foreach (divs[d]) begin
            for (int m = 0; m < 16; m++) begin
                for (int a = 0; a < 16; a++) begin
                    string req;
                    if (divs[d] == 0)            req = "R5 divisor zero rate";
                    else if (m == 0 || a >= m)   req = "R4 fallback rate";
                    else if (a == 0)             req = "R3 integer rate";
                    else                         req = "R1 R2 fractional rate";
                    run_cfg(divs[d], a, m, 1, req);
                end
            end
        end

        // High byte in use: divisor 258
        run_cfg(258, 3, 7, 2, "R1 R2 high byte rate");
        run_cfg(258, 0, 1, 3, "R3 high byte rate");

        // R6: changes while run is high are ignored
        begin
            int cnt;
            @(negedge clk);
            run = 1'b0; div_hi = 8'd0; div_lo = 8'd4; frac_cfg = {4'd3, 4'd1};
            @(negedge clk); @(negedge clk);
            run = 1'b1;
            cnt = 0;
            for (int i = 1; i <= 3 * 16; i++) begin
                @(negedge clk);
                if (i == 5) begin
                    div_lo = 8'd2; frac_cfg = 8'h00;
                end
                if (tick) cnt++;
            end
            check((cnt >= 8) && (cnt <= 10), "R6 rate held during run", cnt, 9);
            check(cfg_err == 1'b0, "R6 cfg_err held during run", int'(cfg_err), 0);
            // R7: run low silences the tick
            run = 1'b0;
            @(negedge clk);
            check(tick == 1'b0, "R7 idle tick", int'(tick), 0);
            @(negedge clk);
            check(cfg_err == 1'b1, "R6 load after run low", int'(cfg_err), 1);
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                check(tick == 1'b0, "R7 idle tick", int'(tick), 0);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule